// File: doc/BRIEF.md
# Bose-Lin Code Check Generator and Self-Checking Checker

This block guards a separable code word: an information field of `INFO_W` bits followed by a check field of `CHK_W` bits. The check value is the number of zero bits in the information field, reduced modulo `2^CHK_W`. With `CHK_W` = 2 the code detects up to two unidirectional errors (modulo 4). With `CHK_W` = 3 it detects up to three (modulo 8). The check field keeps the same width whatever the information width is.

On the checking side, a zero-count generator recomputes the check value from the received information bits. The received check bits are inverted, so that each check position forms a complementary rail pair with the recomputed bit. A chain of two-rail checker cells then folds all pairs into one registered two-bit error pair:

- `01` or `10` marks a valid word.
- `00` or `11` marks a corrupted word, or a fault in the checker itself.

A second, independent zero-count generator drives the encoder output, which supplies check bits to a producer. The block only detects errors; it never corrects them.

Top module: `bose_lin_checker_top`

## Requirements
- R1: `enc_check` equals the number of zero bits in `enc_info`, taken modulo `2^CHK_W`. It follows `enc_info` combinationally, in the same cycle.
- R2: `CHK_W` may be 2 or 3. The width of the check field never depends on `INFO_W`.
- R3: When a clock edge samples a code word, `err_pair` shows `01` or `10` after that edge. A code word is one whose `chk_bits` equal the zero count of `chk_info` modulo `2^CHK_W`.
- R4: When a clock edge samples a word that is not a code word, `err_pair` shows `00` or `11` after that edge.
- R5: Take any code word and flip 1 to `CHK_W` of its bits, anywhere in the information or check field, all in the same direction. The result always gives `00` or `11`.
- R6: While `rst_n` is low, `err_pair` is `01`. It stays `01` until the first rising clock edge after the release.
- R7: `err_pair` changes only at a rising edge of `clk`. Between edges it keeps the result of the word sampled at the previous edge.
- R8: Over the set of code words, `err_pair` takes both values `01` and `10`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the error pair is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_info | input | INFO_W | Information bits to be encoded for a producer |
| enc_check | output | CHK_W | Zero count of `enc_info` modulo 2^CHK_W |
| chk_info | input | INFO_W | Received information field |
| chk_bits | input | CHK_W | Received check field |
| err_pair | output | 2 | Registered two-rail result: 01/10 valid, 00/11 error |

## Verification
The bench runs two instances of the block, one with a 3-bit check field and one with a 2-bit check field. For each, every 8-bit information value is paired with its correct check field. These runs separate a correct zero count from off-by-one, modulo or ones-counting mistakes, and they show that both valid outputs occur.

For a spread of code words, the bench then applies every unidirectional flip pattern of weight 1 to t across the whole word. This shows whether the inverted check rails and the cell chain really turn each such error into a non-complementary pair.

Two further tests complete the picture:
- Random words with wrong check fields confirm that invalid words are flagged.
- A held word that changes mid-cycle shows that the result moves only at a clock edge.

// File: rtl/bose_lin_pkg.sv
package bose_lin_pkg;

    // Value the error pair takes while in reset: a legal, complementary pair.
    localparam logic [1:0] RAIL_RESET = 2'b01;

    // A two-rail pair is a code pair when its rails differ.
    function automatic logic rail_is_code(input logic [1:0] pair);
        return pair[1] ^ pair[0];
    endfunction

endpackage

// File: rtl/bose_lin_zero_count.sv
module bose_lin_zero_count #(
    parameter int INFO_W = 8,
    parameter int CHK_W  = 2
) (
    input  logic [INFO_W-1:0] info,
    output logic [CHK_W-1:0]  count
);

    // The accumulator is exactly CHK_W bits wide, so it wraps modulo 2^CHK_W.
    always_comb begin
        count = '0;
        for (int i = 0; i < INFO_W; i++) begin
            count = count + {{(CHK_W-1){1'b0}}, ~info[i]};
        end
    end

endmodule

// File: rtl/bose_lin_rail_cell.sv
module bose_lin_rail_cell (
    input  logic a0,
    input  logic a1,
    input  logic b0,
    input  logic b1,
    output logic f,
    output logic g
);

    // Two complementary pairs in give a complementary pair out.
    // Any pair with equal rails drives f and g to equal values.
    always_comb begin
        f = (a0 & b0) | (a1 & b1);
        g = (a0 & b1) | (a1 & b0);
    end

endmodule

// File: rtl/bose_lin_rail_tree.sv
module bose_lin_rail_tree #(
    parameter int PAIRS = 2
) (
    input  logic [PAIRS-1:0] rail_x,
    input  logic [PAIRS-1:0] rail_y,
    output logic             out_f,
    output logic             out_g
);

    logic [PAIRS-1:0] stage_f;
    logic [PAIRS-1:0] stage_g;

    assign stage_f[0] = rail_x[0];
    assign stage_g[0] = rail_y[0];

    // Linear chain of cells: each stage folds one more pair into the result.
    for (genvar i = 1; i < PAIRS; i++) begin : g_stage
        bose_lin_rail_cell i_cell (
            .a0 (stage_f[i-1]),
            .a1 (stage_g[i-1]),
            .b0 (rail_x[i]),
            .b1 (rail_y[i]),
            .f  (stage_f[i]),
            .g  (stage_g[i])
        );
    end

    assign out_f = stage_f[PAIRS-1];
    assign out_g = stage_g[PAIRS-1];

endmodule

// File: rtl/bose_lin_checker_top.sv
module bose_lin_checker_top #(
    parameter int INFO_W = 8,
    parameter int CHK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INFO_W-1:0] enc_info,
    output logic [CHK_W-1:0]  enc_check,
    input  logic [INFO_W-1:0] chk_info,
    input  logic [CHK_W-1:0]  chk_bits,
    output logic [1:0]        err_pair
);
    import bose_lin_pkg::*;

    localparam int WORD_W = INFO_W + CHK_W;

    logic [CHK_W-1:0] gen_chk;
    logic [CHK_W-1:0] rail_y;
    logic             tree_f;
    logic             tree_g;
    logic [1:0]       err_q;

    // Producer-side encoder.
    bose_lin_zero_count #(.INFO_W(INFO_W), .CHK_W(CHK_W)) i_enc_gen (
        .info  (enc_info),
        .count (enc_check)
    );

    // Checker-side generator, kept separate from the encoder.
    bose_lin_zero_count #(.INFO_W(INFO_W), .CHK_W(CHK_W)) i_chk_gen (
        .info  (chk_info),
        .count (gen_chk)
    );

    // Inverting the received bits makes a match show up as a complementary pair.
    assign rail_y = ~chk_bits;

    if (CHK_W == 1) begin : g_single
        assign tree_f = gen_chk[0];
        assign tree_g = rail_y[0];
    end else begin : g_chain
        bose_lin_rail_tree #(.PAIRS(CHK_W)) i_tree (
            .rail_x (gen_chk),
            .rail_y (rail_y),
            .out_f  (tree_f),
            .out_g  (tree_g)
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= RAIL_RESET;
        end else begin
            err_q <= {tree_f, tree_g};
        end
    end

    assign err_pair = err_q;

    // R3: a matching word yields a complementary pair one edge later.
    p_code_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_chk == chk_bits) |=> rail_is_code(err_q));

    // R4: a mismatching word yields equal rails one edge later.
    p_noncode_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_chk != chk_bits) |=> !rail_is_code(err_q));

    // R1: both generators agree whenever they see the same information.
    p_enc_matches_gen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_info == chk_info) |-> (enc_check == gen_chk));

    // R6: the first edge after release still shows the reset pair.
    p_reset_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (err_q == RAIL_RESET));

    // R7: with the received word unchanged, the result stays put.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable({chk_info, chk_bits}) && !$rose(rst_n)) |=> $stable(err_q));

    // R2: the width of the check field does not depend on INFO_W.
    logic [WORD_W-1:0] unused_word;
    assign unused_word = {chk_info, chk_bits};

endmodule

// File: tb/test_bose_lin_checker_top.sv
`timescale 1ns/1ps
module test_bose_lin_checker_top;

    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int errors = 0;
    bit seen01 = 0;
    bit seen10 = 0;
    bit done = 0;

    // Instance with a 3-bit check field (t = 3).
    logic [IW-1:0] e3_info = '0;
    logic [2:0]    e3_chk;
    logic [IW-1:0] c3_info = '0;
    logic [2:0]    c3_bits = '0;
    logic [1:0]    c3_err;

    // Instance with a 2-bit check field (t = 2).
    logic [IW-1:0] e2_info = '0;
    logic [1:0]    e2_chk;
    logic [IW-1:0] c2_info = '0;
    logic [1:0]    c2_bits = '0;
    logic [1:0]    c2_err;

    bose_lin_checker_top #(.INFO_W(IW), .CHK_W(3)) i_bose_lin_checker_top (
        .clk(clk), .rst_n(rst_n), .enc_info(e3_info), .enc_check(e3_chk),
        .chk_info(c3_info), .chk_bits(c3_bits), .err_pair(c3_err));

    bose_lin_checker_top #(.INFO_W(IW), .CHK_W(2)) i_bose_lin_checker_top_k2 (
        .clk(clk), .rst_n(rst_n), .enc_info(e2_info), .enc_check(e2_chk),
        .chk_info(c2_info), .chk_bits(c2_bits), .err_pair(c2_err));

    // Reference: count the zeros behaviourally, then reduce.
    function automatic int ref_zeros(input logic [IW-1:0] v, input int modv);
        int z = 0;
        for (int i = 0; i < IW; i++) if (v[i] == 1'b0) z++;
        return z % modv;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at a falling edge; the result is read one clock later, at the next falling edge.
    task automatic run_k3(input logic [IW-1:0] info, input logic [2:0] bits, input bit must_err);
        bit valid;
        @(negedge clk);
        c3_info = info; c3_bits = bits; e3_info = info;
        valid = (ref_zeros(info, 8) == int'(bits)) && !must_err;
        @(negedge clk);
        check(int'(e3_chk) == ref_zeros(info, 8), "R1 k3 encoder", e3_chk, ref_zeros(info, 8));
        if (must_err)
            check(c3_err[1] == c3_err[0], "R5 k3 unidirectional", c3_err, 0);
        else if (valid) begin
            check(c3_err[1] != c3_err[0], "R3 k3 code word", c3_err, 1);
            if (c3_err == 2'b01) seen01 = 1;
            if (c3_err == 2'b10) seen10 = 1;
        end else
            check(c3_err[1] == c3_err[0], "R4 k3 noncode word", c3_err, 0);
    endtask

    task automatic run_k2(input logic [IW-1:0] info, input logic [1:0] bits, input bit must_err);
        bit valid;
        @(negedge clk);
        c2_info = info; c2_bits = bits; e2_info = info;
        valid = (ref_zeros(info, 4) == int'(bits)) && !must_err;
        @(negedge clk);
        check(int'(e2_chk) == ref_zeros(info, 4), "R1 R2 k2 encoder", e2_chk, ref_zeros(info, 4));
        if (must_err)
            check(c2_err[1] == c2_err[0], "R5 k2 unidirectional", c2_err, 0);
        else if (valid)
            check(c2_err[1] != c2_err[0], "R3 k2 code word", c2_err, 1);
        else
            check(c2_err[1] == c2_err[0], "R4 k2 noncode word", c2_err, 0);
    endtask

    initial begin
        #1_250_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset pair is held while rst_n is low.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(c3_err == 2'b01, "R6 reset k3", c3_err, 1);
            check(c2_err == 2'b01, "R6 reset k2", c2_err, 1);
        end
        rst_n = 1'b1;
        #1;
        check(c3_err == 2'b01, "R6 after release", c3_err, 1);

        // R3 R8 R1: every information value with its correct check field.
        for (int v = 0; v < 256; v++) run_k3(v[IW-1:0], 3'(ref_zeros(v[IW-1:0], 8)), 0);
        for (int v = 0; v < 256; v++) run_k2(v[IW-1:0], 2'(ref_zeros(v[IW-1:0], 4)), 0);
        check(seen01 && seen10, "R8 both valid outputs", {seen01, seen10}, 3);

        // R4: random wrong check fields.
        for (int i = 0; i < 100; i++) begin
            logic [IW-1:0] r;
            r = IW'($urandom);
            run_k3(r, 3'(ref_zeros(r, 8) + 1 + ($urandom % 7)), 0);
            run_k2(r, 2'(ref_zeros(r, 4) + 1 + ($urandom % 3)), 0);
        end

        // R5: every unidirectional pattern of weight 1..t across the whole word.
        for (int v = 0; v < 256; v += 4) begin
            logic [10:0] w3;
            logic [9:0]  w2;
            w3 = {v[IW-1:0], 3'(ref_zeros(v[IW-1:0], 8))};
            for (int m = 1; m < 2048; m++) begin
                logic [10:0] mk;
                logic [10:0] bad;
                mk = m[10:0];
                if ($countones(mk) > 3) continue;
                if ((mk & ~w3) == 0) bad = w3 & ~mk;
                else if ((mk & w3) == 0) bad = w3 | mk;
                else continue;
                run_k3(bad[10:3], bad[2:0], 1);
            end
            w2 = {v[IW-1:0], 2'(ref_zeros(v[IW-1:0], 4))};
            for (int m = 1; m < 1024; m++) begin
                logic [9:0] mk;
                logic [9:0] bad;
                mk = m[9:0];
                if ($countones(mk) > 2) continue;
                if ((mk & ~w2) == 0) bad = w2 & ~mk;
                else if ((mk & w2) == 0) bad = w2 | mk;
                else continue;
                run_k2(bad[9:2], bad[1:0], 1);
            end
        end

        // R7: a mid-cycle change is not visible before the next rising edge.
        run_k3(8'hA5, 3'(ref_zeros(8'hA5, 8)), 0);
        @(negedge clk);
        c3_bits = ~c3_bits;
        #1;
        check(c3_err[1] != c3_err[0], "R7 holds between edges", c3_err, 1);
        @(negedge clk);
        check(c3_err[1] == c3_err[0], "R7 updates at edge", c3_err, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule